// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial core of an SPI master. It takes words from a parallel transmit port and shifts them out on the data-out pin while it drives the serial clock. At the same time it assembles the bits arriving on the data-in pin into a parallel receive word. It drives the active-low chip-select pin to frame each transfer. The frame length can be set from 4 to 16 bits. The bit order, the clock idle level, the clock phase and the clock divider are also programmable. All configuration inputs must stay constant while `busy` is high.

Transmit words are offered with a valid/ready handshake. If the next word is already offered when a frame ends, the engine goes straight on into the next frame with no idle clock time, and chip-select stays low. An optional frame-separation mode raises chip-select for one serial clock period between such back-to-back frames. The engine honours this mode only when the clock phase bit is clear. Each received word comes out with a one-cycle valid strobe. A busy flag covers the whole run of consecutive frames.

Top module: `spi_master_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0, `nss_n` is 1, `rx_valid` is 0 and `sck` equals `cfg_cpol`.
- R2: `sck` toggles every `cfg_div_half` clock cycles, so one serial clock period is 2*`cfg_div_half` cycles. A value of 0 acts as 1. The first `sck` edge of a frame comes `cfg_div_half` cycles after `nss_n` falls.
- R3: While the engine is idle, `sck` rests at `cfg_cpol`. With `cfg_cpha`=0, `miso` is sampled on the odd `sck` edges of a frame (1st, 3rd, ...) and `mosi` changes on the even edges. With `cfg_cpha`=1 the two roles are swapped.
- R4: A frame has N = `cfg_len_m1`+1 bits and 2N `sck` edges. Values below 3 act as 3. The received word is right-justified in `rx_data`, and bits N and above are 0.
- R5: When `cfg_lsb_first`=0, bit N-1 of the word is sent first and received bits are placed from bit N-1 downwards. When it is 1, bit 0 goes first and received bits are placed from bit 0 upwards.
- R6: `rx_valid` is high for exactly one cycle. That cycle immediately follows the clock edge on which the last bit of the frame is sampled, and `rx_data` holds the word during it.
- R7: If `tx_valid` is high in the cycle of a frame's last `sck` edge, the word is taken in that cycle. Outside separation mode, the next frame's first edge then follows after `cfg_div_half` cycles and `nss_n` stays low.
- R8: `busy` rises when a transfer starts and stays high across consecutive frames. It falls together with the rise of `nss_n` on the clock of the last frame's final edge, and at that point `sck` is back at `cfg_cpol`.
- R9: With `cfg_nss_pulse`=1 and `cfg_cpha`=0, `nss_n` goes high for exactly 2*`cfg_div_half` cycles between back-to-back frames, starting at the last edge of the previous frame. The next word is taken as `nss_n` falls.
- R10: With `cfg_cpha`=1, `cfg_nss_pulse` has no effect: back-to-back frames run as in R7 and `nss_n` stays low.
- R11: `tx_ready` is high only when `tx_valid` is high, either while idle or at a frame boundary. The word on `tx_data` in that cycle is the word sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset; must be released synchronously to `clk` |
| cfg_len_m1 | input | 4 | Frame length minus one (3..15) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on odd edges; 1: sample on even edges |
| cfg_div_half | input | 8 | Half serial clock period in clock cycles |
| cfg_nss_pulse | input | 1 | Request chip-select separation between back-to-back frames |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 16 | Received word, right-justified |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_n | output | 1 | Active-low chip select |

## Verification
With the phase bit set, the last edge of a frame is a sampling edge. On that same clock the engine finishes the received word and raises `rx_valid`, takes the next transmit word through `tx_ready`, and reloads its shift state. With the phase bit clear, the same reload instead coincides with the first bit of the next word being placed on `mosi`. The bench brings this about by keeping `tx_valid` high across three-frame runs in every combination of polarity, phase, bit order, length, divider and separation request. A bus model samples the pins, using the `mosi` value from before each edge. It judges the collision by checking that the completed word equals the word sent and that `rx_valid` carries the model's word in that exact cycle. It also checks that the next frame's first edge arrives one half period later with no corruption of either word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Sequencer states of the shift engine
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/spi_eng_tick.sv
// Half-period tick generator: one pulse every div_half cycles while enabled.
module spi_eng_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (DIV_W+1)'(1);
  // A divider of zero behaves like one: the comparison is then always true
  assign tick    = en && (cnt_inc >= {1'b0, div_half});

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_eng_bitpos.sv
// Maps a bit's transfer order to its position in the word.
module spi_eng_bitpos #(
  parameter int LEN_W = 4
) (
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             lsb_first,
  output logic [LEN_W-1:0] pos
);

  assign pos = lsb_first ? idx : (len_m1 - idx);

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(DATA_W)-1:0]   cfg_len_m1,
  input  logic                        cfg_lsb_first,
  input  logic                        cfg_cpol,
  input  logic                        cfg_cpha,
  input  logic [DIV_W-1:0]            cfg_div_half,
  input  logic                        cfg_nss_pulse,
  input  logic                        tx_valid,
  input  logic [DATA_W-1:0]           tx_data,
  output logic                        tx_ready,
  output logic                        rx_valid,
  output logic [DATA_W-1:0]           rx_data,
  output logic                        busy,
  output logic                        sck,
  output logic                        mosi,
  input  logic                        miso,
  output logic                        nss_n
);

  localparam int LEN_W   = $clog2(DATA_W);
  localparam int EDGE_W  = LEN_W + 1;
  localparam int MIN_LEN = 3;

  eng_state_e        state_q, state_d;
  logic [EDGE_W-1:0] edge_q, edge_d;       // sck edges done in this frame
  logic [LEN_W-1:0]  oidx_q, oidx_d;       // transfer index of bit on mosi
  logic [DATA_W-1:0] txw_q, txw_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              rxv_q, rxv_d;
  logic              phase_q, phase_d;     // sck relative to idle level
  logic              nss_q, nss_d;
  logic              gap_q, gap_d;

  logic              tick;
  logic [LEN_W-1:0]  len_m1;
  logic              pulse_eff;
  logic              samp_edge, last_edge, last_samp;
  logic [LEN_W-1:0]  samp_idx, shift_idx, samp_pos, tx_pos;
  logic [DATA_W-1:0] merged;

  // Frame length floor of four bits
  assign len_m1    = (cfg_len_m1 < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : cfg_len_m1;
  // Separation pulses only with phase bit clear
  assign pulse_eff = cfg_nss_pulse & ~cfg_cpha;

  // Edge k = edge_q+1; odd k samples when cpha=0, even k when cpha=1
  assign samp_edge = ~edge_q[0] ^ cfg_cpha;
  assign samp_idx  = edge_q[EDGE_W-1:1];
  assign shift_idx = edge_q[EDGE_W-1:1] + LEN_W'(~cfg_cpha & edge_q[0]);
  assign last_edge = tick && (edge_q == {len_m1, 1'b1});
  assign last_samp = (samp_idx == len_m1);

  spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (state_q != ST_IDLE),
    .div_half (cfg_div_half),
    .tick     (tick)
  );

  spi_eng_bitpos #(.LEN_W(LEN_W)) u_rx_pos (
    .idx       (samp_idx),
    .len_m1    (len_m1),
    .lsb_first (cfg_lsb_first),
    .pos       (samp_pos)
  );

  spi_eng_bitpos #(.LEN_W(LEN_W)) u_tx_pos (
    .idx       (oidx_q),
    .len_m1    (len_m1),
    .lsb_first (cfg_lsb_first),
    .pos       (tx_pos)
  );

  assign merged = acc_q | (DATA_W'(miso) << samp_pos);

  // Word hand-off: from idle, at a frame's last edge, or at the end of a gap
  assign tx_ready = tx_valid && (
                      (state_q == ST_IDLE) ||
                      ((state_q == ST_XFER) && last_edge && !pulse_eff) ||
                      ((state_q == ST_GAP) && tick && gap_q));

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    oidx_d  = oidx_q;
    txw_d   = txw_q;
    acc_d   = acc_q;
    rxd_d   = rxd_q;
    rxv_d   = 1'b0;
    phase_d = phase_q;
    gap_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        phase_d = 1'b0;
        if (tx_valid) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (tick) begin
          phase_d = ~phase_q;
          edge_d  = edge_q + EDGE_W'(1);
          if (samp_edge) begin
            if (last_samp) begin
              rxd_d = merged;
              rxv_d = 1'b1;
              acc_d = '0;
            end else begin
              acc_d = merged;
            end
          end else begin
            oidx_d = shift_idx;
          end
          if (last_edge) begin
            if (!tx_valid)      state_d = ST_IDLE;
            else if (pulse_eff) state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        gap_d = gap_q ^ tick;
        if (tick && gap_q) state_d = tx_valid ? ST_XFER : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (tx_ready) begin
      txw_d  = tx_data;
      edge_d = '0;
      oidx_d = '0;
      acc_d  = '0;
    end
  end

  assign nss_d = (state_d != ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      oidx_q  <= '0;
      txw_q   <= '0;
      acc_q   <= '0;
      rxd_q   <= '0;
      rxv_q   <= 1'b0;
      phase_q <= 1'b0;
      nss_q   <= 1'b1;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      oidx_q  <= oidx_d;
      txw_q   <= txw_d;
      acc_q   <= acc_d;
      rxd_q   <= rxd_d;
      rxv_q   <= rxv_d;
      phase_q <= phase_d;
      nss_q   <= nss_d;
      gap_q   <= gap_d;
    end
  end

  assign sck      = phase_q ^ cfg_cpol;
  assign mosi     = (state_q == ST_XFER) & txw_q[tx_pos];
  assign nss_n    = nss_q;
  assign busy     = (state_q != ST_IDLE);
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

endmodule

module spi_master_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic cfg_cpha,
  input logic cfg_nss_pulse,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic busy,
  input logic sck,
  input logic nss_n
);

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nss_n);

  // R3
  idle_sck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_cpol));

  // R6
  rx_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (nss_n && (sck == cfg_cpol)));

  // R10
  gap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nss_n) |-> (cfg_nss_pulse && !cfg_cpha));

  // R11
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);

endmodule

bind spi_master_engine spi_master_engine_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_cpol      (cfg_cpol),
  .cfg_cpha      (cfg_cpha),
  .cfg_nss_pulse (cfg_nss_pulse),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .rx_valid      (rx_valid),
  .busy          (busy),
  .sck           (sck),
  .nss_n         (nss_n)
);

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;

  localparam int DW    = 16;
  localparam int DIVW  = 8;
  localparam int NFR   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [3:0]      cfg_len_m1;
  logic            cfg_lsb_first, cfg_cpol, cfg_cpha, cfg_nss_pulse;
  logic [DIVW-1:0] cfg_div_half;
  logic            tx_valid;
  logic [DW-1:0]   tx_data;
  logic            tx_ready, rx_valid, busy, sck, mosi, nss_n;
  logic [DW-1:0]   rx_data;
  logic            miso = 1'b0;

  spi_master_engine #(.DATA_W(DW), .DIV_W(DIVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_m1(cfg_len_m1), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div_half(cfg_div_half),
    .cfg_nss_pulse(cfg_nss_pulse), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .nss_n(nss_n)
  );

  int checks = 0, failures = 0, cyc = 0;
  int tnum = 0, n = 4, h = 1;
  int sf, scnt, ref_cyc, pulse_start, pulses, busy_falls;
  bit pulse_pend, mon_on = 1'b0, done = 1'b0;
  logic [DW-1:0] scap;
  logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_nss = 1'b1, prev_busy = 1'b0;

  function automatic logic [DW-1:0] txw(int t, int f);
    return DW'((t * 37 + f * 1013 + 5) ^ (f * 7919 + t * 3));
  endfunction

  function automatic logic [DW-1:0] sw(int t, int f);
    return DW'((t * 53 + f * 2029 + 11) ^ (t * 611));
  endfunction

  function automatic int bpos(int i);
    return cfg_lsb_first ? i : (n - 1 - i);
  endfunction

  function automatic logic [DW-1:0] mask();
    return DW'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (test %0d)", req, act, exp, tnum);
    end
  endtask

  // Bus model and timing monitor, sampled mid-cycle
  always @(negedge clk) begin
    logic [DW-1:0] w;
    bit got_rx;
    bit edge_seen;
    cyc++;
    got_rx = 1'b0;
    if (mon_on) begin
      edge_seen = (sck != prev_sck) && !prev_nss;
      if (prev_nss && !nss_n) begin
        if (pulse_pend) begin
          // R9 separation width
          chk((cyc - pulse_start) == 2 * h, "R9", cyc - pulse_start, 2 * h);
          pulse_pend = 1'b0;
        end
        ref_cyc = cyc;
        if (!cfg_cpha) begin
          w = sw(tnum, sf);
          miso = w[bpos(0)];
        end
      end
      if (!prev_nss && nss_n && busy) begin
        pulse_pend  = 1'b1;
        pulse_start = cyc;
        pulses++;
      end
      if (edge_seen) begin
        // R2 R7: edge spacing, no idle gap between back-to-back frames
        chk((cyc - ref_cyc) == h, "R2 R7", cyc - ref_cyc, h);
        ref_cyc = cyc;
        if ((sck != cfg_cpol) ^ cfg_cpha) begin
          // R3 sampling edge
          scap[bpos(scnt)] = prev_mosi;
          scnt++;
          if (scnt == n) begin
            chk(scap == (txw(tnum, sf) & mask()), "R5 R11", int'(scap), int'(txw(tnum, sf) & mask()));
            chk(rx_valid === 1'b1, "R6", int'(rx_valid), 1);
            chk(rx_data == (sw(tnum, sf) & mask()), "R4 R5", int'(rx_data), int'(sw(tnum, sf) & mask()));
            got_rx = 1'b1;
            sf++;
            scnt = 0;
            scap = '0;
          end
        end else begin
          w = sw(tnum, sf);
          miso = w[bpos(scnt)];
        end
      end
      if (rx_valid && !got_rx) chk(1'b0, "R6", 1, 0);
      if (prev_busy && !busy) begin
        busy_falls++;
        chk(nss_n && (sck == cfg_cpol), "R8", {30'd0, nss_n, sck}, {30'd0, 1'b1, cfg_cpol});
      end
    end
    prev_sck  = sck;
    prev_mosi = mosi;
    prev_nss  = nss_n;
    prev_busy = busy;
  end

  task automatic run_test(input bit pol, input bit pha, input bit lsb,
                          input int len, input int div, input bit pul);
    bit hit;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    cfg_len_m1 = 4'(len - 1); cfg_div_half = DIVW'(div); cfg_nss_pulse = pul;
    tnum++; n = len; h = div;
    sf = 0; scnt = 0; scap = '0; pulses = 0; busy_falls = 0; pulse_pend = 1'b0;
    repeat (2) @(negedge clk);
    // R3 idle level
    chk(!busy && nss_n && (sck == pol), "R3", {29'd0, busy, nss_n, sck}, {30'd1, pol});
    mon_on = 1'b1;
    for (int f = 0; f < NFR; f++) begin
      tx_data  = txw(tnum, f);
      tx_valid = 1'b1;
      do begin
        #1;
        hit = tx_ready;
        @(negedge clk);
      end while (!hit);
    end
    tx_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    chk(sf == NFR, "R4", sf, NFR);
    chk(busy_falls == 1, "R8", busy_falls, 1);
    if (pul && !pha) chk(pulses == NFR - 1, "R9", pulses, NFR - 1);
    else if (pul)    chk(pulses == 0, "R10", pulses, 0);
    else             chk(pulses == 0, "R7", pulses, 0);
  endtask

  initial begin
    int lens[3];
    lens[0] = 4; lens[1] = 9; lens[2] = 16;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0;
    cfg_len_m1 = 4'd7; cfg_lsb_first = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_div_half = 8'd2; cfg_nss_pulse = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && nss_n && !rx_valid && (sck == cfg_cpol), "R1",
        {28'd0, busy, nss_n, rx_valid, sck}, 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && nss_n && !rx_valid && !tx_ready, "R1",
        {28'd0, busy, nss_n, rx_valid, tx_ready}, 32'h4);

    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++)
          for (int li = 0; li < 3; li++)
            for (int d = 1; d <= 3; d += 2)
              for (int s = 0; s < 2; s++)
                run_test(p[0], c[0], l[0], lens[li], d, s[0]);

    // R1: reset in the middle of a frame
    @(negedge clk);
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div_half = 8'd3; cfg_len_m1 = 4'd15;
    tx_data = 16'hA5C3; tx_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk(busy && !nss_n, "R8", {30'd0, busy, nss_n}, 2);
    rst_n = 1'b0;
    #1;
    tx_valid = 1'b0;
    chk(!busy && nss_n && !rx_valid && sck, "R1",
        {28'd0, busy, nss_n, rx_valid, sck}, 32'h5);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && nss_n && sck, "R1", {29'd0, busy, nss_n, sck}, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired (R7 handshake stall)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule